// File: doc/BRIEF.md
# LCD Line-Fetch Bus-Request Engine

This block moves one display line of pixel bytes from display memory to an external LCD driver each time a horizontal line-start pulse arrives. It works out from the segment count and the pixel depth how many bytes the line needs. It then raises a bus request to hold the CPU off the shared memory bus and waits for the grant. Once granted, it streams the bytes out at the rate the memory bus allows and spends a fixed number of extra overhead cycles that depend on the kind of display memory. After that it drops the request.

The memory bus cost per byte depends on the bus width and on the wait states. A 32-bit bus can deliver several bytes in one system clock, so the output port is four byte lanes wide with a lane-keep mask. The block counts the cycles for which it held the bus on each line and presents the count when the line ends, so the bus occupancy can be compared with its closed-form value.

Top module: `lcd_line_fetch`

## Requirements
- R1: The bytes fetched per line equal ceil(seg_count × K / 8). K comes from bpp_mode: 0→1, 1→2, 2→4, 3→8, 4→12, 5→16, 6 and 7→24.
- R2: A line_start sampled while idle raises bus_req on the next cycle. No memory read (mem_rd) and no output beat occur until bus_grant has been sampled high. bus_req stays high for the rest of the fetch.
- R3: Per-byte cost, counted in eighths of a clock, is (2+wait_states)×4 when width_mode is 0 or 3 (16-bit bus), ×2 when it is 1 (32-bit, half), and ×1 when it is 2 (32-bit, quarter). After the c-th data cycle the bytes delivered total min(B, floor(8c/cost)).
- R4: Each beat carries up to 4 bytes, low-aligned. Lane i (bits 8i+7:8i) holds the next byte in address order, ld_keep is a contiguous mask from bit 0, and unused lanes read zero. Bytes come from consecutive addresses starting at line_base.
- R5: After the data cycles, overhead cycles follow. mem_kind 0 (SRAM) and 3 add 0. mem_kind 2 (SDRAM) adds 9. mem_kind 1 (internal RAM) adds 1 plus one for each 64-byte block boundary the line's address range crosses.
- R6: At the end of the overhead, bus_req falls and line_done pulses for one cycle. In that same cycle stall_cycles shows data cycles + overhead cycles.
- R7: A line_start that arrives while a fetch is active raises overrun for one cycle and leaves the running fetch unchanged.
- R8: The configuration inputs and line_base are sampled at line start. Changes during a fetch do not affect it.
- R9: After reset, bus_req, mem_rd, ld_valid, ld_keep, line_done, overrun and stall_cycles are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Line-start pulse from horizontal sync |
| line_base | input | ADDR_W | Byte address of the line in display memory |
| seg_count | input | SEG_W | Number of display segments per line |
| bpp_mode | input | 3 | Pixel depth selector |
| width_mode | input | 2 | Memory bus width / access mode |
| wait_states | input | WS_W | Wait states per external access |
| mem_kind | input | 2 | Display memory type |
| bus_req | output | 1 | Request to hold the CPU off the bus |
| bus_grant | input | 1 | Bus granted to this block |
| mem_rd | output | 1 | Memory read in this cycle |
| mem_addr | output | ADDR_W | Byte address of lane 0 of the read |
| mem_rdata | input | 32 | Four bytes from mem_addr upward |
| ld_data | output | 32 | Byte lanes to the LCD driver |
| ld_keep | output | 4 | Valid lanes of ld_data |
| ld_valid | output | 1 | Beat strobe |
| line_done | output | 1 | End-of-line pulse |
| stall_cycles | output | STALL_W | Cycles the bus was held on the last line |
| overrun | output | 1 | Line start arrived during a fetch |

## Verification
The bench uses the default parameters: 10-bit segment count, 3-bit wait states, 16-bit addresses and 64-byte internal RAM blocks. With these, all three bus modes can be reached, including the quarter mode at zero waits, which fills all four lanes in every beat. Short lines placed next to block edges make the internal RAM boundary rule observable. A segment count that is not a multiple of eight gives a partial last byte. Long lines at seven wait states exercise pacing with a fractional carry.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;
  localparam int LANES  = 4;
  localparam int TAKE_W = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DATA, ST_OVH} fetch_state_t;

  localparam logic [1:0] MEM_SRAM  = 2'd0;
  localparam logic [1:0] MEM_IRAM  = 2'd1;
  localparam logic [1:0] MEM_SDRAM = 2'd2;

  localparam logic [1:0] BUS_W16   = 2'd0;
  localparam logic [1:0] BUS_HALF  = 2'd1;
  localparam logic [1:0] BUS_QUART = 2'd2;

  localparam int SDRAM_OVH = 9;

  function automatic logic [4:0] pixel_bits(input logic [2:0] mode);
    case (mode)
      3'd0:    pixel_bits = 5'd1;
      3'd1:    pixel_bits = 5'd2;
      3'd2:    pixel_bits = 5'd4;
      3'd3:    pixel_bits = 5'd8;
      3'd4:    pixel_bits = 5'd12;
      3'd5:    pixel_bits = 5'd16;
      default: pixel_bits = 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/lcdf_line_calc.sv
module lcdf_line_calc
  import lcdf_pkg::*;
#(
  parameter int SEG_W    = 10,
  parameter int WS_W     = 3,
  parameter int ADDR_W   = 16,
  parameter int BLK_LOG2 = 6,
  parameter int BYTES_W  = SEG_W + 2,
  parameter int COST_W   = WS_W + 3
) (
  input  logic [SEG_W-1:0]   seg_count,
  input  logic [2:0]         bpp_mode,
  input  logic [1:0]         width_mode,
  input  logic [WS_W-1:0]    wait_states,
  input  logic [1:0]         mem_kind,
  input  logic [ADDR_W-1:0]  line_base,
  output logic [BYTES_W-1:0] line_bytes,
  output logic [COST_W-1:0]  byte_cost,
  output logic [ADDR_W-1:0]  ovh_cycles
);
  localparam int PROD_W = SEG_W + 6;

  logic [PROD_W-1:0] bit_total;
  logic [COST_W-1:0] unit_cost;
  logic [ADDR_W-1:0] last_addr;
  logic [ADDR_W-1:0] crossings;

  // ceil(seg * K / 8)
  always_comb begin
    bit_total  = PROD_W'(seg_count) * PROD_W'(pixel_bits(bpp_mode)) + PROD_W'(7);
    line_bytes = BYTES_W'(bit_total >> 3);
  end

  // cost per byte in eighths of a system clock
  always_comb begin
    unit_cost = COST_W'(wait_states) + COST_W'(2);
    case (width_mode)
      BUS_HALF:  byte_cost = unit_cost << 1;
      BUS_QUART: byte_cost = unit_cost;
      default:   byte_cost = unit_cost << 2;
    endcase
  end

  // internal RAM block changes across the line's address span
  always_comb begin
    last_addr = line_base + ADDR_W'(line_bytes) - ADDR_W'(1);
    crossings = (last_addr >> BLK_LOG2) - (line_base >> BLK_LOG2);
    case (mem_kind)
      MEM_IRAM:  ovh_cycles = crossings + ADDR_W'(1);
      MEM_SDRAM: ovh_cycles = ADDR_W'(SDRAM_OVH);
      default:   ovh_cycles = '0;
    endcase
  end
endmodule

// File: rtl/lcdf_pacer.sv
module lcdf_pacer
  import lcdf_pkg::*;
#(
  parameter int COST_W  = 6,
  parameter int BYTES_W = 12
) (
  input  logic [COST_W:0]    credit,
  input  logic [COST_W-1:0]  cost,
  input  logic [BYTES_W-1:0] remaining,
  output logic [TAKE_W-1:0]  take,
  output logic [COST_W:0]    credit_next
);
  localparam int PW = COST_W + 4;

  logic [PW-1:0]    avail;
  logic [LANES-1:0] fits;

  assign avail = PW'(credit) + PW'(8);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_fit
    assign fits[g] = (PW'(g + 1) * PW'(cost) <= avail) &&
                     (BYTES_W'(g + 1) <= remaining);
  end

  always_comb begin
    take = '0;
    for (int i = 0; i < LANES; i++) begin
      if (fits[i]) take = TAKE_W'(i + 1);
    end
  end

  assign credit_next = (COST_W + 1)'(avail - PW'(take) * PW'(cost));
endmodule

// File: rtl/lcdf_beat_pack.sv
module lcdf_beat_pack
  import lcdf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [TAKE_W-1:0]    take,
  input  logic [LANES*8-1:0]   rdata,
  output logic                 ld_valid,
  output logic [LANES-1:0]     ld_keep,
  output logic [LANES*8-1:0]   ld_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_keep  <= '0;
      ld_data  <= '0;
    end else begin
      ld_valid <= fire && (take != '0);
      for (int i = 0; i < LANES; i++) begin
        if (fire && (TAKE_W'(i) < take)) begin
          ld_keep[i]       <= 1'b1;
          ld_data[i*8 +: 8] <= rdata[i*8 +: 8];
        end else begin
          ld_keep[i]       <= 1'b0;
          ld_data[i*8 +: 8] <= 8'h00;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_line_fetch.sv
module lcd_line_fetch
  import lcdf_pkg::*;
#(
  parameter int SEG_W    = 10,
  parameter int WS_W     = 3,
  parameter int ADDR_W   = 16,
  parameter int BLK_LOG2 = 6,
  parameter int STALL_W  = SEG_W + WS_W + 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_start,
  input  logic [ADDR_W-1:0]    line_base,
  input  logic [SEG_W-1:0]     seg_count,
  input  logic [2:0]           bpp_mode,
  input  logic [1:0]           width_mode,
  input  logic [WS_W-1:0]      wait_states,
  input  logic [1:0]           mem_kind,
  output logic                 bus_req,
  input  logic                 bus_grant,
  output logic                 mem_rd,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic [LANES*8-1:0]   mem_rdata,
  output logic [LANES*8-1:0]   ld_data,
  output logic [LANES-1:0]     ld_keep,
  output logic                 ld_valid,
  output logic                 line_done,
  output logic [STALL_W-1:0]   stall_cycles,
  output logic                 overrun
);
  localparam int BYTES_W = SEG_W + 2;
  localparam int COST_W  = WS_W + 3;

  fetch_state_t       state;
  logic [BYTES_W-1:0] calc_bytes, bytes_left;
  logic [COST_W-1:0]  calc_cost, cost_q;
  logic [ADDR_W-1:0]  calc_ovh, ovh_left, cur_addr;
  logic [COST_W:0]    credit, credit_nx;
  logic [TAKE_W-1:0]  take;
  logic [STALL_W-1:0] stall_cnt;
  logic               last_beat;

  lcdf_line_calc #(
    .SEG_W(SEG_W), .WS_W(WS_W), .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2),
    .BYTES_W(BYTES_W), .COST_W(COST_W)
  ) u_calc (
    .seg_count  (seg_count),
    .bpp_mode   (bpp_mode),
    .width_mode (width_mode),
    .wait_states(wait_states),
    .mem_kind   (mem_kind),
    .line_base  (line_base),
    .line_bytes (calc_bytes),
    .byte_cost  (calc_cost),
    .ovh_cycles (calc_ovh)
  );

  lcdf_pacer #(.COST_W(COST_W), .BYTES_W(BYTES_W)) u_pacer (
    .credit     (credit),
    .cost       (cost_q),
    .remaining  (bytes_left),
    .take       (take),
    .credit_next(credit_nx)
  );

  assign mem_rd    = (state == ST_DATA);
  assign mem_addr  = cur_addr;
  assign last_beat = (BYTES_W'(take) == bytes_left);

  lcdf_beat_pack u_pack (
    .clk     (clk),
    .rst     (rst),
    .fire    (mem_rd),
    .take    (take),
    .rdata   (mem_rdata),
    .ld_valid(ld_valid),
    .ld_keep (ld_keep),
    .ld_data (ld_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      bus_req      <= 1'b0;
      line_done    <= 1'b0;
      overrun      <= 1'b0;
      stall_cycles <= '0;
      stall_cnt    <= '0;
      bytes_left   <= '0;
      cost_q       <= '0;
      ovh_left     <= '0;
      cur_addr     <= '0;
      credit       <= '0;
    end else begin
      line_done <= 1'b0;
      overrun   <= line_start && (state != ST_IDLE);
      case (state)
        ST_IDLE: begin
          if (line_start) begin
            bytes_left <= calc_bytes;
            cost_q     <= calc_cost;
            ovh_left   <= calc_ovh;
            cur_addr   <= line_base;
            state      <= ST_REQ;
            bus_req    <= 1'b1;
          end
        end
        ST_REQ: begin
          if (bus_grant) begin
            state     <= ST_DATA;
            stall_cnt <= '0;
            credit    <= '0;
          end
        end
        ST_DATA: begin
          stall_cnt  <= stall_cnt + STALL_W'(1);
          bytes_left <= bytes_left - BYTES_W'(take);
          cur_addr   <= cur_addr + ADDR_W'(take);
          credit     <= credit_nx;
          if (last_beat) begin
            if (ovh_left != '0) begin
              state <= ST_OVH;
            end else begin
              state        <= ST_IDLE;
              bus_req      <= 1'b0;
              line_done    <= 1'b1;
              stall_cycles <= stall_cnt + STALL_W'(1);
            end
          end
        end
        default: begin
          stall_cnt <= stall_cnt + STALL_W'(1);
          ovh_left  <= ovh_left - ADDR_W'(1);
          if (ovh_left == ADDR_W'(1)) begin
            state        <= ST_IDLE;
            bus_req      <= 1'b0;
            line_done    <= 1'b1;
            stall_cycles <= stall_cnt + STALL_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lcdf_checker.sv
module lcdf_checker #(
  parameter int STALL_W = 17
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_req,
  input logic               bus_grant,
  input logic               mem_rd,
  input logic               ld_valid,
  input logic [3:0]         ld_keep,
  input logic               line_done,
  input logic [STALL_W-1:0] stall_cycles,
  input logic               overrun
);
  // R2: reads only happen under a held request
  a_r2_read_under_req: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> bus_req);

  // R2: the read phase starts only after the grant was sampled
  a_r2_read_after_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd) |-> $past(bus_grant));

  // R4: lane mask is contiguous from lane 0
  a_r4_keep_contiguous: assert property (@(posedge clk) disable iff (rst)
    $onehot0(4'(ld_keep + 4'd1)));

  // R3: strobe and lane mask agree
  a_r3_valid_has_lanes: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> (ld_keep != 4'd0));

  // R4: a beat follows a memory read
  a_r4_beat_from_read: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(mem_rd));

  // R6: releasing the bus coincides with end of line
  a_r6_release_done: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req) |-> line_done);

  // R6: a finished line always reports a nonzero stall
  a_r6_stall_nonzero: assert property (@(posedge clk) disable iff (rst)
    line_done |-> (stall_cycles != '0));

  // R7: overrun flags only while a fetch was active
  a_r7_overrun_busy: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(bus_req));
endmodule

bind lcd_line_fetch lcdf_checker #(.STALL_W(STALL_W)) u_lcdf_checker (
  .clk         (clk),
  .rst         (rst),
  .bus_req     (bus_req),
  .bus_grant   (bus_grant),
  .mem_rd      (mem_rd),
  .ld_valid    (ld_valid),
  .ld_keep     (ld_keep),
  .line_done   (line_done),
  .stall_cycles(stall_cycles),
  .overrun     (overrun)
);

// File: tb/test_lcd_line_fetch.sv
module test_lcd_line_fetch;
  localparam int SEG_W = 10, WS_W = 3, ADDR_W = 16, STALL_W = SEG_W + WS_W + 4;

  logic clk = 1'b0, rst = 1'b1;
  logic line_start = 1'b0, bus_grant = 1'b0;
  logic [ADDR_W-1:0] line_base = '0;
  logic [SEG_W-1:0]  seg_count = '0;
  logic [2:0]        bpp_mode = '0;
  logic [1:0]        width_mode = '0, mem_kind = '0;
  logic [WS_W-1:0]   wait_states = '0;
  logic              bus_req, mem_rd, ld_valid, line_done, overrun;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_rdata, ld_data;
  logic [3:0]        ld_keep;
  logic [STALL_W-1:0] stall_cycles;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] byte_at(input int a);
    byte_at = 8'(((a & 16'hFFFF) * 13 + 5) & 255);
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++) mem_rdata[i*8 +: 8] = byte_at(int'(mem_addr) + i);
  end

  lcd_line_fetch #(.SEG_W(SEG_W), .WS_W(WS_W), .ADDR_W(ADDR_W)) i_lcd_line_fetch (
    .clk(clk), .rst(rst), .line_start(line_start), .line_base(line_base),
    .seg_count(seg_count), .bpp_mode(bpp_mode), .width_mode(width_mode),
    .wait_states(wait_states), .mem_kind(mem_kind), .bus_req(bus_req),
    .bus_grant(bus_grant), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .ld_data(ld_data), .ld_keep(ld_keep),
    .ld_valid(ld_valid), .line_done(line_done), .stall_cycles(stall_cycles),
    .overrun(overrun)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int k_of(input int m);
    case (m)
      0: k_of = 1; 1: k_of = 2; 2: k_of = 4; 3: k_of = 8;
      4: k_of = 12; 5: k_of = 16; default: k_of = 24;
    endcase
  endfunction

  // reference: cumulative bytes after c data cycles
  function automatic int cum(input int c, input int nb, input int cost);
    int v;
    v = (8 * c) / cost;
    cum = (v < nb) ? v : nb;
  endfunction

  task automatic run_line(input int seg, input int bpp, input int wm, input int ws,
                          input int kind, input int base, input int gdelay,
                          input bit do_ovr, input bit do_cfg);
    int nb, cost, dcyc, ovh, total, prev, now, exp_n;
    nb   = (seg * k_of(bpp) + 7) / 8;                       // R1
    cost = (2 + ws) * ((wm == 1) ? 2 : (wm == 2) ? 1 : 4);  // R3
    dcyc = (nb * cost + 7) / 8;
    if (kind == 2)      ovh = 9;                            // R5
    else if (kind == 1) ovh = 1 + (((base + nb - 1) >> 6) - (base >> 6));
    else                ovh = 0;
    total = dcyc + ovh;

    @(negedge clk);
    seg_count = SEG_W'(seg); bpp_mode = 3'(bpp); width_mode = 2'(wm);
    wait_states = WS_W'(ws); mem_kind = 2'(kind); line_base = ADDR_W'(base);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    chk("R2 req after line start", int'(bus_req), 1);
    for (int g = 0; g < gdelay; g++) begin
      @(negedge clk);
      chk("R2 req held before grant", int'(bus_req), 1);
      chk("R2 no read before grant", int'(mem_rd), 0);
      chk("R2 no beat before grant", int'(ld_valid), 0);
    end
    bus_grant = 1'b1;
    prev = 0;
    for (int c = 0; c <= total + 1; c++) begin
      @(negedge clk);
      if (c == 0 && do_cfg) begin  // R8: disturb inputs mid-fetch
        seg_count = SEG_W'(seg + 77); bpp_mode = 3'(bpp ^ 3); width_mode = 2'(wm ^ 1);
        wait_states = WS_W'(ws ^ 5); mem_kind = 2'(kind ^ 2); line_base = ADDR_W'(base + 300);
      end
      now   = (c >= 1 && c <= dcyc) ? cum(c, nb, cost) : prev;
      exp_n = now - prev;
      chk($sformatf("R3 bytes in beat %0d", c), $countones(ld_keep), exp_n);
      chk($sformatf("R3 valid in beat %0d", c), int'(ld_valid), (exp_n > 0) ? 1 : 0);
      for (int j = 0; j < 4; j++) begin
        chk($sformatf("R4 lane %0d beat %0d", j, c), int'(ld_data[j*8 +: 8]),
            (j < exp_n) ? int'(byte_at(base + prev + j)) : 0);
      end
      chk($sformatf("R6 bus_req cycle %0d", c), int'(bus_req), (c < total) ? 1 : 0);
      chk($sformatf("R6 line_done cycle %0d", c), int'(line_done), (c == total) ? 1 : 0);
      if (c == total) chk("R5 R6 stall cycles", int'(stall_cycles), total);
      if (do_ovr && c == 1) line_start = 1'b1;
      if (do_ovr && c == 2) line_start = 1'b0;
      chk($sformatf("R7 overrun cycle %0d", c), int'(overrun), (do_ovr && c == 2) ? 1 : 0);
      prev = now;
    end
    chk("R1 total bytes", prev, nb);
    bus_grant = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk("R9 bus_req", int'(bus_req), 0);
    chk("R9 mem_rd", int'(mem_rd), 0);
    chk("R9 ld_valid", int'(ld_valid), 0);
    chk("R9 ld_keep", int'(ld_keep), 0);
    chk("R9 line_done", int'(line_done), 0);
    chk("R9 overrun", int'(overrun), 0);
    chk("R9 stall_cycles", int'(stall_cycles), 0);

    run_line(40, 0, 0, 0, 0,   0, 0, 1'b0, 1'b0); // mono, SRAM, 1 byte/clk
    run_line(33, 1, 1, 1, 1,  60, 2, 1'b0, 1'b0); // partial byte, IRAM crossing
    run_line(20, 3, 2, 0, 2,   8, 1, 1'b1, 1'b0); // 4 lanes/clk, SDRAM, overrun
    run_line(30, 4, 0, 3, 1,   0, 3, 1'b0, 1'b1); // slow bus, config change
    run_line(16, 5, 1, 2, 3, 500, 0, 1'b0, 1'b0); // kind 3 as SRAM
    run_line(10, 6, 2, 1, 1, 120, 1, 1'b1, 1'b0); // 24 bpp, block crossing
    run_line(64, 2, 2, 7, 1,   0, 2, 1'b0, 1'b0); // no crossing, fractional pace
    run_line(12, 7, 0, 0, 2, 255, 0, 1'b0, 1'b1); // mode 7 as 24 bpp

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule